// File: doc/BRIEF.md
# Chip-Select Wait-State Bus Controller

This block sets the timing of each access on a small external bus, counted in bus clock cycles. A requester presents an address and a read/write flag. The block sorts the address into one of three regions: the special-function register space, on-chip ROM/RAM, or one of four external chip-select windows. It then drives a one-hot chip-select strobe, a read or a write strobe, and a one-cycle completion pulse. The length of each access follows fixed rules for the two internal regions. For the external windows, the length follows two software-written configuration registers.

Each external window has a one-bit fast-timing flag and a two-bit stretch code. When the flag is set, reads take one cycle and writes take two, and the stretch code is ignored. When the flag is clear, the stretch code sets a length of two, three or four cycles for both directions. In that mode only, an external ready input can hold the access open beyond its programmed length. The block takes a snapshot of the configuration at the moment an access starts. A register write therefore never alters an access that is already running.

Top module: `csw_bus_ctrl`

## Requirements
- R1: Addresses below 0x0400 belong to the register region, addresses from 0x0400 up to 0x7FFF belong to on-chip memory, and addresses from 0x8000 upward are external with window index addr[14:13]. Only external accesses raise a chip-select bit, namely bit index of `cs_o`, and it stays high through every cycle of the access.
- R2: Register-region accesses last 2 cycles for reads and writes, whatever the configuration holds and whatever `rdy_i` does.
- R3: On-chip memory accesses last 1 cycle for reads and writes, whatever the configuration holds and whatever `rdy_i` does.
- R4: With the window's fast-timing bit at 1, a read lasts 1 cycle and a write 2 cycles, the stretch code is ignored, and `rdy_i` has no effect.
- R5: With the fast-timing bit at 0, the window's stretch code sets the length for both directions: 00 gives 2 cycles, 01 gives 3 and 10 gives 4.
- R6: Stretch code 11 is reserved. It gives 4 cycles. Writing it into any window field sets `cfg_err_o`, which stays set until reset.
- R7: For an external window with fast-timing 0, `rdy_i` is sampled from the last programmed cycle onward. Each cycle it is low adds one cycle, and the access ends in the first such cycle where it is high.
- R8: The configuration is written with `cfg_we_i`. `cfg_sel_i`=0 loads `cfg_wdata_i[3:0]` as the fast-timing bits (bit i for window i). `cfg_sel_i`=1 loads all 8 bits as stretch codes (bits [2i+1:2i] for window i). Both are readable on `wsel_o` and `wexp_o`.
- R9: A configuration write made while an access is running does not change that access's length. It applies from the next access.
- R10: A request is taken when `req_i` is high while `busy_o` is low. From the following cycle on, `busy_o` and the read or write strobe are high for every cycle of the access. `done_o` is high for exactly one cycle, the final one, and all strobes drop after it.
- R11: After reset both configuration registers read zero, `cfg_err_o` is low, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request, taken when idle |
| req_addr_i | input | 16 | Access address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| rdy_i | input | 1 | External ready, high = device ready |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 1 | 0 = fast-timing register, 1 = stretch-code register |
| cfg_wdata_i | input | 8 | Configuration write data |
| busy_o | output | 1 | Access in progress |
| cs_o | output | 4 | One-hot external chip selects |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| done_o | output | 1 | Final-cycle pulse |
| wsel_o | output | 4 | Fast-timing register contents |
| wexp_o | output | 8 | Stretch-code register contents |
| cfg_err_o | output | 1 | Sticky reserved-code flag |

## Verification
The hardest state to reach from the ports is a configuration write that lands in the middle of an external access. That access also has to be long enough for the new value to matter. The stimulus reaches it by issuing the write on the first cycle of a running access, both in directed cases and at random. It then checks that the running access keeps its old length and that the next access takes the new one. Ready stretching is exercised by holding `rdy_i` low for a random number of cycles past the programmed end, on windows and regions where it is allowed and on those where it must be ignored.

// File: rtl/csw_pkg.sv
// Package: shared types and widths for the chip-select wait-state controller.
// Assumes at most four external windows and access lengths of up to 4 programmed cycles.
package csw_pkg;
    typedef enum logic [1:0] {
        RG_SFR = 2'd0,
        RG_INT = 2'd1,
        RG_EXT = 2'd2
    } region_e;

    localparam int LEN_W = 3;

    // Length for a cleared fast-timing bit, from the two-bit stretch code.
    function automatic logic [LEN_W-1:0] stretch_len(input logic [1:0] code);
        case (code)
            2'b00:   stretch_len = 3'd2;
            2'b01:   stretch_len = 3'd3;
            default: stretch_len = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/csw_cfg_regs.sv
// Module: configuration register pair (fast-timing bits and stretch codes) plus
// the sticky reserved-code flag. Assumes one write port; no read mux is needed
// because both registers are exposed as parallel outputs.
module csw_cfg_regs #(
    parameter int NCS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [2*NCS-1:0] wdata,
    output logic [NCS-1:0]   wsel_q,
    output logic [2*NCS-1:0] wexp_q,
    output logic             err_q
);
    logic [NCS-1:0] code_rsvd;

    // Flag each stretch-code field of the write data that holds the reserved code.
    for (genvar i = 0; i < NCS; i++) begin : g_rsvd
        assign code_rsvd[i] = (wdata[2*i +: 2] == 2'b11);
    end

    // Register update and sticky error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel_q <= '0;
            wexp_q <= '0;
            err_q  <= 1'b0;
        end else if (we) begin
            if (!sel) begin
                wsel_q <= wdata[NCS-1:0];
            end else begin
                wexp_q <= wdata;
                if (|code_rsvd) begin
                    err_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/csw_addr_dec.sv
// Module: address decoder. Sorts an address into register space, on-chip memory
// or an external window, and produces the one-hot window select. Assumes
// SFR_END < INT_END and that external space is addressed from INT_END upward.
module csw_addr_dec
    import csw_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          NCS     = 4,
    parameter logic [AW-1:0] SFR_END = 16'h0400,
    parameter logic [AW-1:0] INT_END = 16'h8000,
    parameter int          CS_LSB  = 13
) (
    input  logic [AW-1:0]          addr,
    output region_e                region,
    output logic [$clog2(NCS)-1:0] cs_idx,
    output logic [NCS-1:0]         cs_hot
);
    localparam int CSW = $clog2(NCS);

    // Region compare against the two boundaries.
    always_comb begin
        if (addr < SFR_END) begin
            region = RG_SFR;
        end else if (addr < INT_END) begin
            region = RG_INT;
        end else begin
            region = RG_EXT;
        end
    end

    assign cs_idx = addr[CS_LSB +: CSW];

    // One-hot window select, raised only for external addresses.
    for (genvar i = 0; i < NCS; i++) begin : g_hot
        assign cs_hot[i] = (region == RG_EXT) && (cs_idx == CSW'(i));
    end
endmodule

// File: rtl/csw_len_calc.sv
// Module: access length calculator. Picks the programmed cycle count for a
// request from its region, direction and the window's configuration, and says
// whether the ready input may stretch it. Purely combinational.
module csw_len_calc
    import csw_pkg::*;
#(
    parameter int NCS = 4
) (
    input  region_e                region,
    input  logic [$clog2(NCS)-1:0] cs_idx,
    input  logic                   write,
    input  logic [NCS-1:0]         wsel,
    input  logic [2*NCS-1:0]       wexp,
    output logic [LEN_W-1:0]       len,
    output logic                   stretch_ok
);
    logic       fast;
    logic [1:0] code;

    assign fast = wsel[cs_idx];
    assign code = wexp[2*cs_idx +: 2];

    // Length and stretch permission by region and window mode.
    always_comb begin
        stretch_ok = 1'b0;
        case (region)
            RG_SFR:  len = 3'd2;
            RG_INT:  len = 3'd1;
            default: begin
                if (fast) begin
                    len = write ? 3'd2 : 3'd1;
                end else begin
                    len        = stretch_len(code);
                    stretch_ok = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/csw_cycle_fsm.sv
// Module: bus cycle sequencer. Captures a request with its length and strobes,
// counts the programmed cycles down, and holds the last cycle open while the
// ready input is low when stretching is permitted. Assumes len >= 1.
module csw_cycle_fsm
    import csw_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             write,
    input  logic [NCS-1:0]   cs_hot,
    input  logic [LEN_W-1:0] len,
    input  logic             stretch_ok,
    input  logic             rdy,
    output logic             busy,
    output logic [NCS-1:0]   cs,
    output logic             rd,
    output logic             wr,
    output logic             done
);
    logic             active_q;
    logic [LEN_W-1:0] rem_q;
    logic             write_q;
    logic             stretch_q;
    logic [NCS-1:0]   cs_q;
    logic             last;

    assign last = active_q && (rem_q == '0);
    assign done = last && (!stretch_q || rdy);

    // Request capture, cycle countdown and release on the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            rem_q     <= '0;
            write_q   <= 1'b0;
            stretch_q <= 1'b0;
            cs_q      <= '0;
        end else if (!active_q) begin
            if (req) begin
                active_q  <= 1'b1;
                rem_q     <= len - 1'b1;
                write_q   <= write;
                stretch_q <= stretch_ok;
                cs_q      <= cs_hot;
            end
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end else if (done) begin
            active_q <= 1'b0;
            cs_q     <= '0;
        end
    end

    assign busy = active_q;
    assign cs   = cs_q;
    assign rd   = active_q && !write_q;
    assign wr   = active_q && write_q;
endmodule

// File: rtl/csw_bus_ctrl.sv
// Module: top of the chip-select wait-state controller. Ties the configuration
// registers, decoder, length calculator and sequencer together. The length is
// computed from the live registers only at request acceptance, so register
// writes never affect a running access.
module csw_bus_ctrl
    import csw_pkg::*;
#(
    parameter int            AW      = 16,
    parameter int            NCS     = 4,
    parameter logic [AW-1:0] SFR_END = 16'h0400,
    parameter logic [AW-1:0] INT_END = 16'h8000,
    parameter int            CS_LSB  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic             req_write_i,
    input  logic             rdy_i,
    input  logic             cfg_we_i,
    input  logic             cfg_sel_i,
    input  logic [2*NCS-1:0] cfg_wdata_i,
    output logic             busy_o,
    output logic [NCS-1:0]   cs_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             done_o,
    output logic [NCS-1:0]   wsel_o,
    output logic [2*NCS-1:0] wexp_o,
    output logic             cfg_err_o
);
    localparam int CSW = $clog2(NCS);

    region_e          region;
    logic [CSW-1:0]   cs_idx;
    logic [NCS-1:0]   cs_hot;
    logic [LEN_W-1:0] len;
    logic             stretch_ok;

    csw_cfg_regs #(.NCS(NCS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we_i),
        .sel    (cfg_sel_i),
        .wdata  (cfg_wdata_i),
        .wsel_q (wsel_o),
        .wexp_q (wexp_o),
        .err_q  (cfg_err_o)
    );

    csw_addr_dec #(
        .AW(AW), .NCS(NCS), .SFR_END(SFR_END), .INT_END(INT_END), .CS_LSB(CS_LSB)
    ) u_dec (
        .addr   (req_addr_i),
        .region (region),
        .cs_idx (cs_idx),
        .cs_hot (cs_hot)
    );

    csw_len_calc #(.NCS(NCS)) u_len (
        .region     (region),
        .cs_idx     (cs_idx),
        .write      (req_write_i),
        .wsel       (wsel_o),
        .wexp       (wexp_o),
        .len        (len),
        .stretch_ok (stretch_ok)
    );

    csw_cycle_fsm #(.NCS(NCS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_i),
        .write      (req_write_i),
        .cs_hot     (cs_hot),
        .len        (len),
        .stretch_ok (stretch_ok),
        .rdy        (rdy_i),
        .busy       (busy_o),
        .cs         (cs_o),
        .rd         (rd_o),
        .wr         (wr_o),
        .done       (done_o)
    );
endmodule

// File: rtl/csw_bus_ctrl_checker.sv
// Module: protocol checker for csw_bus_ctrl, attached by bind. Observes ports only.
module csw_bus_ctrl_checker #(
    parameter int NCS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic [NCS-1:0]   cs_o,
    input logic             rd_o,
    input logic             wr_o,
    input logic             done_o,
    input logic             cfg_err_o
);
    // R1: at most one window selected.
    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    // R1: window and direction held through the access.
    assert_strobe_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> ($stable(cs_o) && $stable(rd_o) && $stable(wr_o)));

    // R10: an access only ends with done, and done only inside an access.
    assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_done_in_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_release_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (cs_o == '0 && !rd_o && !wr_o && !done_o));

    // R10: exactly one direction strobe while busy.
    assert_one_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rd_o ^ wr_o));

    // R11: no strobe while idle.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_o == '0 && !rd_o && !wr_o));

    // R6: reserved-code flag is sticky.
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);
endmodule

bind csw_bus_ctrl csw_bus_ctrl_checker #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .cs_o      (cs_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .done_o    (done_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/csw_bus_ctrl_bench.sv
`timescale 1ns/100ps
module csw_bus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic        req_write_i = 1'b0;
    logic        rdy_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic        cfg_sel_i = 1'b0;
    logic [7:0]  cfg_wdata_i = '0;
    logic        busy_o, rd_o, wr_o, done_o, cfg_err_o;
    logic [3:0]  cs_o, wsel_o;
    logic [7:0]  wexp_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_wsel = '0;
    logic [7:0] m_wexp = '0;
    logic       m_err = 1'b0;

    always #2.5 clk = ~clk;

    csw_bus_ctrl u_csw_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
        .req_write_i(req_write_i), .rdy_i(rdy_i), .cfg_we_i(cfg_we_i),
        .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .busy_o(busy_o),
        .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o),
        .wsel_o(wsel_o), .wexp_o(wexp_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Programmed length from the requirements.
    function automatic int exp_len(input logic [15:0] a, input logic w,
                                   input logic [3:0] ws, input logic [7:0] we);
        int idx;
        if (a < 16'h0400) return 2;
        if (a < 16'h8000) return 1;
        idx = int'(a[14:13]);
        if (ws[idx]) return w ? 2 : 1;
        case (we[2*idx +: 2])
            2'b00: return 2;
            2'b01: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic bit exp_stretch(input logic [15:0] a, input logic [3:0] ws);
        return (a >= 16'h8000) && !ws[a[14:13]];
    endfunction

    function automatic logic [3:0] exp_cs(input logic [15:0] a);
        return (a >= 16'h8000) ? (4'b0001 << a[14:13]) : 4'b0000;
    endfunction

    task automatic model_write(input logic sel, input logic [7:0] d);
        if (!sel) m_wsel = d[3:0];
        else begin
            m_wexp = d;
            for (int i = 0; i < 4; i++) if (d[2*i +: 2] == 2'b11) m_err = 1'b1;
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
        model_write(sel, d);
        #1;
        chk(wsel_o == m_wsel, "R8 wsel readback", wsel_o, m_wsel);
        chk(wexp_o == m_wexp, "R8 wexp readback", wexp_o, m_wexp);
        chk(cfg_err_o == m_err, "R6 err flag", cfg_err_o, m_err);
    endtask

    // One access; rdy_i low until cycle len+extra; optional config write on cycle 1.
    task automatic access(input logic [15:0] a, input logic w, input int extra,
                          input bit mid, input logic msel, input logic [7:0] mdata,
                          input string tag);
        int l, thr, tot, got;
        bit st, bad;
        l   = exp_len(a, w, m_wsel, m_wexp);
        st  = exp_stretch(a, m_wsel);
        thr = l + extra;
        tot = st ? thr : l;
        got = 0; bad = 0;
        @(negedge clk);
        req_i = 1'b1; req_addr_i = a; req_write_i = w; rdy_i = (thr <= 0);
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            req_i = 1'b0;
            rdy_i = (n >= thr);
            if (mid && n == 1) begin
                cfg_we_i = 1'b1; cfg_sel_i = msel; cfg_wdata_i = mdata;
            end else begin
                cfg_we_i = 1'b0;
            end
            #1;
            if (!(busy_o && cs_o == exp_cs(a) && rd_o == !w && wr_o == w)) bad = 1;
            if (done_o) begin got = n; break; end
        end
        if (mid) model_write(msel, mdata);
        chk(!bad, {tag, " R1/R10 strobes"}, bad, 0);
        chk(got == tot, {tag, " length"}, got, tot);
        @(negedge clk);
        cfg_we_i = 1'b0; rdy_i = 1'b1;
        #1;
        chk(!busy_o && !done_o && cs_o == 4'b0, "R10 release", busy_o, 0);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(wsel_o == 0 && wexp_o == 0, "R11 regs zero", {wsel_o, wexp_o}, 0);
        chk(!cfg_err_o && !busy_o && cs_o == 0 && !rd_o && !wr_o, "R11 quiet", busy_o, 0);

        // R3 on-chip memory; R2 register region, even with rdy low and odd config
        cfg_write(1'b0, 8'h0F);
        access(16'h0400, 1'b0, 3, 0, 0, 0, "R3 int read");
        access(16'h7FFF, 1'b1, 3, 0, 0, 0, "R3 int write");
        access(16'h0000, 1'b0, 3, 0, 0, 0, "R2 sfr read");
        access(16'h03FF, 1'b1, 3, 0, 0, 0, "R2 sfr write");
        // R4 fast-timing windows, rdy ignored, stretch code ignored
        cfg_write(1'b1, 8'h92);
        access(16'h8000, 1'b0, 2, 0, 0, 0, "R4 cs0 read");
        access(16'hA000, 1'b1, 2, 0, 0, 0, "R4 cs1 write");
        access(16'hFFFF, 1'b1, 0, 0, 0, 0, "R4 cs3 write");
        // R5 stretch codes
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h24);  // cs0=00 cs1=01 cs2=10 cs3=00
        access(16'h8000, 1'b0, 0, 0, 0, 0, "R5 code00");
        access(16'hA010, 1'b1, 0, 0, 0, 0, "R5 code01");
        access(16'hC000, 1'b0, 0, 0, 0, 0, "R5 code10");
        // R7 ready stretch
        access(16'hA000, 1'b0, 3, 0, 0, 0, "R7 stretch3");
        access(16'hE000, 1'b1, 1, 0, 0, 0, "R7 stretch1");
        // R6 reserved code
        cfg_write(1'b1, 8'hC0);
        access(16'hE000, 1'b0, 0, 0, 0, 0, "R6 code11");
        cfg_write(1'b1, 8'h00);
        chk(cfg_err_o == 1'b1, "R6 sticky", cfg_err_o, 1);
        // R9 mid-access configuration write
        cfg_write(1'b1, 8'h20);  // cs2 = 10 -> 4 cycles
        access(16'hC000, 1'b0, 0, 1, 1'b1, 8'h00, "R9 running");
        access(16'hC000, 1'b0, 0, 0, 0, 0, "R9 next");
        access(16'hC000, 1'b1, 0, 1, 1'b0, 8'h04, "R9 running fast");
        access(16'hC000, 1'b1, 0, 0, 0, 0, "R9 next fast");

        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a;
            int r;
            r = $urandom_range(0, 9);
            if (r < 2) a = 16'($urandom_range(0, 16'h03FF));
            else if (r < 4) a = 16'($urandom_range(16'h0400, 16'h7FFF));
            else a = 16'($urandom_range(16'h8000, 16'hFFFF));
            if ($urandom_range(0, 5) == 0)
                cfg_write(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
            access(a, 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                   ($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
                   8'($urandom_range(0, 255)), "R7/R9 random");
        end
        cfg_write(1'b0, 8'h0A);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule